// File: doc/BRIEF.md
# Seven-Level Multicarrier PWM Modulator

This block drives the twelve switch gates of one phase leg of a seven-level inverter. A signed reference sample is compared each clock against six triangular carriers stacked in equal bands, three above zero and three below. The number of carriers that the reference exceeds gives one of seven output levels, from -3 to +3 units. That level is then decoded into the gate pattern that the selected inverter structure needs.

All six carriers come from one shared up/down counter. Their relative phase follows one of three arrangements: all in phase; the lower half inverted against the upper half; or each band inverted against its neighbour. The gate decoder supports three structures: diode-clamped, flying-capacitor and cascaded H-bridge. The arrangement and structure selects take effect only at the start of a carrier period, so a carrier period is never cut into pieces that follow different rules.

Top module: `ml7_pwm`

## Requirements
- R1: `lvl_o` is a 3-bit two's complement value equal to the number of carriers strictly below the registered reference, minus 3, so it always lies in -3..+3.
- R2: The shared count starts at 0 after reset and steps by one each clock: up to `PEAK`, then down to 0, with a period of 2*`PEAK` clocks. Band k (k = 0 lowest .. 5 highest) carries (k-3)*`PEAK` plus either the count or, when the band is inverted, `PEAK` minus the count.
- R3: With `arr_i` = 0 no band is inverted.
- R4: With `arr_i` = 1 bands 0..2 (below zero) are inverted and bands 3..5 are not.
- R5: With `arr_i` = 2 the odd bands 1, 3 and 5 are inverted, so adjacent bands always have opposite phase.
- R6: With `topo_i` = 0 (diode-clamped) gate bits 3-L through 8-L are 1 and all others 0, where L is the level and bit 0 is the first switch.
- R7: With `topo_i` = 1 (flying-capacitor) bits 0..5 hold L+3 ones filled from bit 0, and bits 6..11 hold 3-L ones filled from bit 6.
- R8: With `topo_i` = 2 (cascaded bridges) bridge b occupies bits 4b..4b+3. It shows 4'b1001 when L >= 3-b, 4'b0110 when L <= -(b+1), and 4'b0011 otherwise.
- R9: `ref_i` is registered once before the comparison, and the level and gates are registered after it, so the outputs reflect `ref_i` two clocks after it is applied.
- R10: While reset is asserted `lvl_o` is 0 and every gate bit is 0.
- R11: `arr_i` and `topo_i` are sampled only on a clock edge where the count is 0. A change at any other time has no effect on the outputs until the next such edge. After reset both act as 0 until first sampled.
- R12: A reference of 3*`PEAK`+1 or more gives level +3, and a reference of -3*`PEAK` or less gives level -3, in every arrangement and at every count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | REF_W | Signed reference sample |
| arr_i | input | 2 | Carrier arrangement: 0 in phase, 1 halves opposed, 2 alternating |
| topo_i | input | 2 | Inverter structure: 0 diode-clamped, 1 flying-capacitor, 2 cascaded bridges |
| lvl_o | output | 3 | Selected level, two's complement |
| gate_o | output | 12 | Switch gates, bit 0 is the first switch |

## Verification
The reference is swept by single steps across the full carrier span and two codes beyond each end. Each value is held for three clocks while the carriers keep moving, and every pairing of the three arrangements with the three structures is covered. Because the count differs from sample to sample, the sweep tells the arrangements apart by which band flips its comparison at a given count, and tells the structures apart by the gate bits for the same level. Select changes land mid-period, which exposes any select that acts before the count returns to 0. Explicit steps from the bottom to the top of the range pin down the two-clock latency and the saturated levels.

// File: rtl/ml7_pwm_pkg.sv
package ml7_pwm_pkg;
  localparam int NUM_BANDS = 6;
  localparam int NUM_GATES = 12;

  typedef enum logic [1:0] {
    ARR_SAME = 2'd0,
    ARR_HALF = 2'd1,
    ARR_ALT  = 2'd2
  } arr_e;

  typedef enum logic [1:0] {
    TOPO_DCL = 2'd0,
    TOPO_FCP = 2'd1,
    TOPO_HBR = 2'd2
  } topo_e;
endpackage

// File: rtl/ml7_tri_cnt.sv
module ml7_tri_cnt #(
  parameter int PEAK = 20,
  localparam int CNT_W = $clog2(PEAK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_o <= up_q ? cnt_o + 1'b1 : cnt_o - 1'b1;
      if (up_q && cnt_o == CNT_W'(PEAK - 1)) up_q <= 1'b0;
      else if (!up_q && cnt_o == CNT_W'(1))  up_q <= 1'b1;
    end
  end

  assign wrap_o = (cnt_o == '0);
endmodule

// File: rtl/ml7_carrier_cmp.sv
module ml7_carrier_cmp
  import ml7_pwm_pkg::*;
#(
  parameter int REF_W = 10,
  parameter int PEAK  = 20,
  localparam int CNT_W = $clog2(PEAK + 1),
  localparam int CW    = REF_W + 2
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  arr_e                    arr_i,
  output logic [2:0]              nbelow_o
);
  logic [NUM_BANDS-1:0] hit;
  logic signed [CW-1:0] ref_x;
  logic signed [CW-1:0] up_v, dn_v;

  assign ref_x = CW'(ref_i);
  assign up_v  = $signed(CW'(cnt_i));
  assign dn_v  = $signed(CW'(PEAK)) - up_v;

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    localparam int OFS = (k - 3) * PEAK;
    logic inv;
    logic signed [CW-1:0] car;
    always_comb begin
      unique case (arr_i)
        ARR_HALF: inv = (k < 3);
        ARR_ALT:  inv = (k % 2 == 1);
        default:  inv = 1'b0;
      endcase
    end
    assign car    = $signed(CW'(OFS)) + (inv ? dn_v : up_v);
    assign hit[k] = (ref_x > car);
  end

  always_comb begin
    nbelow_o = '0;
    for (int k = 0; k < NUM_BANDS; k++) nbelow_o = nbelow_o + 3'(hit[k]);
  end
endmodule

// File: rtl/ml7_gate_map.sv
module ml7_gate_map
  import ml7_pwm_pkg::*;
(
  input  logic signed [2:0]     lvl_i,
  input  topo_e                 topo_i,
  output logic [NUM_GATES-1:0]  gate_o
);
  int l;
  assign l = int'(lvl_i);

  always_comb begin
    gate_o = '0;
    unique case (topo_i)
      TOPO_FCP: begin
        for (int i = 0; i < 6; i++) begin
          gate_o[i]     = (i < l + 3);
          gate_o[6 + i] = (i < 3 - l);
        end
      end
      TOPO_HBR: begin
        for (int b = 0; b < 3; b++) begin
          if (l >= 3 - b)         gate_o[4*b +: 4] = 4'b1001;
          else if (l <= -(b + 1)) gate_o[4*b +: 4] = 4'b0110;
          else                    gate_o[4*b +: 4] = 4'b0011;
        end
      end
      default: begin
        for (int i = 0; i < NUM_GATES; i++)
          gate_o[i] = (i >= 3 - l) && (i < 9 - l);
      end
    endcase
  end
endmodule

// File: rtl/ml7_pwm.sv
module ml7_pwm
  import ml7_pwm_pkg::*;
#(
  parameter int REF_W = 10,
  parameter int PEAK  = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [1:0]              arr_i,
  input  logic [1:0]              topo_i,
  output logic signed [2:0]       lvl_o,
  output logic [11:0]             gate_o
);
  localparam int CNT_W = $clog2(PEAK + 1);

  logic [CNT_W-1:0]        cnt;
  logic                    wrap;
  logic signed [REF_W-1:0] ref_q;
  arr_e                    arr_q;
  topo_e                   topo_q;
  logic [2:0]              nbelow;
  logic signed [3:0]       lvl_w;
  logic signed [2:0]       lvl_d;
  logic [NUM_GATES-1:0]    gate_d;

  ml7_tri_cnt #(.PEAK(PEAK)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      arr_q  <= ARR_SAME;
      topo_q <= TOPO_DCL;
    end else begin
      ref_q <= ref_i;
      if (wrap) begin
        arr_q  <= arr_e'(arr_i);
        topo_q <= topo_e'(topo_i);
      end
    end
  end

  ml7_carrier_cmp #(.REF_W(REF_W), .PEAK(PEAK)) u_cmp (
    .ref_i   (ref_q),
    .cnt_i   (cnt),
    .arr_i   (arr_q),
    .nbelow_o(nbelow)
  );

  assign lvl_w = $signed({1'b0, nbelow}) - 4'sd3;
  assign lvl_d = lvl_w[2:0];

  ml7_gate_map u_map (
    .lvl_i (lvl_d),
    .topo_i(topo_q),
    .gate_o(gate_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= '0;
      gate_o <= '0;
    end else begin
      lvl_o  <= lvl_d;
      gate_o <= gate_d;
    end
  end
endmodule

// File: rtl/ml7_pwm_chk.sv
module ml7_pwm_chk #(
  parameter int REF_W = 10,
  parameter int PEAK  = 20,
  localparam int CNT_W = $clog2(PEAK + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic signed [2:0]       lvl_o,
  input logic [11:0]             gate_o,
  input logic [CNT_W-1:0]        cnt,
  input logic                    wrap,
  input logic [1:0]              arr_q,
  input logic [1:0]              topo_q,
  input logic signed [REF_W-1:0] ref_q
);
  localparam logic signed [REF_W-1:0] SPAN = REF_W'(3 * PEAK);

  AST_LVL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o != -3'sd4); // R1

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(PEAK)); // R2

  AST_SIX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != '0) |-> ($countones(gate_o) == 6)); // R6

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> ($stable(arr_q) && $stable(topo_q))); // R11

  AST_TOP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_q > SPAN) |=> (lvl_o == 3'sd3)); // R12

  AST_BOT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_q <= -SPAN) |=> (lvl_o == -3'sd3)); // R12
endmodule

bind ml7_pwm ml7_pwm_chk #(.REF_W(REF_W), .PEAK(PEAK)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .lvl_o (lvl_o),
  .gate_o(gate_o),
  .cnt   (cnt),
  .wrap  (wrap),
  .arr_q (arr_q),
  .topo_q(topo_q),
  .ref_q (ref_q)
);

// File: tb/ml7_pwm_bench.sv
module ml7_pwm_bench;
  localparam int REF_W = 10;
  localparam int PEAK  = 20;
  localparam int CLK_PERIOD = 10;
  localparam int SPAN = 3 * PEAK;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [REF_W-1:0] ref_i = '0;
  logic [1:0] arr_i = 2'd0;
  logic [1:0] topo_i = 2'd0;
  logic signed [2:0] lvl_o;
  logic [11:0] gate_o;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ml7_pwm #(.REF_W(REF_W), .PEAK(PEAK)) u_ml7_pwm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_i),
    .arr_i (arr_i),
    .topo_i(topo_i),
    .lvl_o (lvl_o),
    .gate_o(gate_o)
  );

  function automatic int count_below(int r, int c, int arr);
    int n = 0;
    for (int k = 0; k < 6; k++) begin
      bit inv = (arr == 1) ? (k < 3) : (arr == 2) ? (k % 2 == 1) : 1'b0;
      int car = (k - 3) * PEAK + (inv ? PEAK - c : c);
      if (r > car) n++;
    end
    return n;
  endfunction

  function automatic logic [11:0] gates_for(int l, int topo);
    logic [11:0] g = '0;
    if (topo == 1) begin
      g[5:0]  = 6'((1 << (l + 3)) - 1);
      g[11:6] = 6'((1 << (3 - l)) - 1);
    end else if (topo == 2) begin
      for (int b = 0; b < 3; b++)
        g[4*b +: 4] = (l >= 3 - b) ? 4'b1001 : (l <= -(b + 1)) ? 4'b0110 : 4'b0011;
    end else begin
      g = 12'(12'h03F << (3 - l));
    end
    return g;
  endfunction

  // bench model of the requirements, stepped on the same edges
  int m_cnt, m_ref, m_arr, m_topo, e_lvl;
  bit m_up;
  logic [11:0] e_gate;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= 0; m_up <= 1'b1; m_ref <= 0; m_arr <= 0; m_topo <= 0;
      e_lvl <= 0; e_gate <= '0;
    end else begin
      e_lvl  <= count_below(m_ref, m_cnt, m_arr) - 3;
      e_gate <= gates_for(count_below(m_ref, m_cnt, m_arr) - 3, m_topo);
      m_ref  <= int'(ref_i);
      if (m_cnt == 0) begin
        m_arr  <= int'(arr_i);
        m_topo <= int'(topo_i);
      end
      m_cnt <= m_up ? m_cnt + 1 : m_cnt - 1;
      if (m_up && m_cnt == PEAK - 1) m_up <= 1'b0;
      else if (!m_up && m_cnt == 1) m_up <= 1'b1;
    end
  end

  function automatic string tag_of(int arr, int topo);
    string a = (arr == 1) ? "R4" : (arr == 2) ? "R5" : "R3";
    string t = (topo == 1) ? "R7" : (topo == 2) ? "R8" : "R6";
    return {"R1 R2 R9 R11 ", a, " ", t};
  endfunction

  always @(negedge clk_i) begin
    if (live && rst_ni) begin
      checks++;
      if (int'(lvl_o) != e_lvl || gate_o != e_gate) begin
        errors++;
        $display("FAIL %s lvl act=%0d exp=%0d gate act=%03h exp=%03h",
                 tag_of(m_arr, m_topo), lvl_o, e_lvl, gate_o, e_gate);
      end
    end
  end

  task automatic check_lvl(string tag, int exp);
    checks++;
    if (int'(lvl_o) != exp) begin
      errors++;
      $display("FAIL %s lvl act=%0d exp=%0d", tag, lvl_o, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ref_i = 10'sd50;
    arr_i = 2'd2;
    topo_i = 2'd1;
    repeat (3) @(negedge clk_i);
    // R10: outputs held at zero in reset
    checks++;
    if (lvl_o != 3'sd0 || gate_o != '0) begin
      errors++;
      $display("FAIL R10 act lvl=%0d gate=%03h exp lvl=0 gate=000", lvl_o, gate_o);
    end
    rst_ni = 1'b1;
    live = 1'b1;

    // R9 and R12: step from bottom to top, latency of two clocks
    ref_i = REF_W'(-SPAN);
    repeat (3) @(negedge clk_i);
    check_lvl("R12 bottom", -3);
    ref_i = REF_W'(SPAN + 1);
    @(negedge clk_i);
    check_lvl("R9 one clock", -3);
    @(negedge clk_i);
    check_lvl("R9 two clocks", 3);

    // full sweep over arrangements and structures, selects changed mid-period
    for (int a = 0; a < 3; a++) begin
      for (int t = 0; t < 3; t++) begin
        arr_i  = 2'(a);
        topo_i = 2'(t);
        for (int r = -SPAN - 2; r <= SPAN + 2; r++) begin
          ref_i = REF_W'(r);
          repeat (3) @(negedge clk_i);
        end
      end
    end

    // R12 at every count in each arrangement
    for (int a = 0; a < 3; a++) begin
      arr_i = 2'(a);
      ref_i = REF_W'(SPAN + 1);
      repeat (2 * PEAK + 2) @(negedge clk_i);
      check_lvl("R12 top", 3);
      ref_i = REF_W'(-SPAN - 1);
      repeat (2) @(negedge clk_i);
      check_lvl("R12 bottom", -3);
    end

    live = 1'b0;
    finish_run();
  end
endmodule